// File: doc/BRIEF.md
# Video Processor Host Port

This block sits between a host CPU bus and a tile-based video display processor. It decodes single-cycle host accesses to four byte-wide ports: a data read port, a status read port, a data write port and a control write port. Through these ports the host moves bytes to and from video RAM and programs the processor's control registers.

The control port takes commands as byte pairs. A one-bit latch records whether the first byte of a pair has arrived. The second byte completes the command, which is one of three kinds: a control-register load, a write-address load or a read-address load. Any data-port access, and any status read, clears that latch. A command that is half sent when such an access happens is therefore dropped without any notice.

Video RAM sits behind a plain synchronous single-port interface with a 14-bit address that increments by itself. A read-ahead byte buffer lets a host read of the data port return at once while the next byte is fetched in the background. The frame-interrupt flag is set by a tick from the display timing. A status read returns the flag and then clears it.

Top module: `vdp_host_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `host_rvalid`, `irq`, `vram_en` and all of `creg_flat` are 0.
- R2: A single control-port byte leaves every control register unchanged. A command takes effect only on the second control byte, and the new register value is visible in the cycle after that byte.
- R3: The second control byte is decoded on bits 7:6. If bit 7 is 1, the command is a register load: the first byte is written to the register numbered by bits 2:0. If bits 7:6 are 01, the command is a write-address load, and if they are 00 it is a read-address load. In both address cases the address is {second[5:0], first[7:0]}.
- R4: A data-port read, a data-port write or a status read that falls between the two control bytes clears the pending first byte. The next control byte is then taken as a first byte.
- R5: A data-port write drives `vram_en`=1, `vram_we`=1, `vram_addr` equal to the current address and `vram_wdata` equal to the byte, all in the cycle after the host write. The address then advances by one.
- R6: A read-address load issues a video-RAM read of the loaded address in the next cycle. A data-port read returns the read-ahead byte on `host_rdata` with `host_rvalid`=1 one cycle after the access, then fetches the byte at the current address and advances the address.
- R7: A data-port write also loads the read-ahead buffer, so a data-port read that follows returns the written byte.
- R8: The address wraps from 0x3FFF to 0x0000.
- R9: `frame_tick` sets the frame flag, which drives `irq`, from the next cycle on. A status read returns {flag, 7'b0} and then clears the flag. If a tick and a status read fall in the same cycle, the read returns the old flag and the flag stays set.
- R10: The data read port is at 0x8800 and the status port at 0x8802. The data write port is at 0x9800 and the control port at 0x9802. A write to a read port, a read from a write port, or any access to another address changes nothing and produces no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | One-cycle host access strobe |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | Pulses one cycle after a decoded read |
| frame_tick | input | 1 | End-of-frame pulse from display timing |
| irq | output | 1 | Frame interrupt, high while the flag is set |
| vram_en | output | 1 | Video-RAM access enable |
| vram_we | output | 1 | Video-RAM write enable |
| vram_addr | output | 14 | Video-RAM address |
| vram_wdata | output | 8 | Video-RAM write byte |
| vram_rdata | input | 8 | Video-RAM read byte, valid the cycle after a read enable |
| creg_flat | output | 64 | Eight control registers, register n in bits 8n+7:8n |

## Verification
Each result has a fixed latency from the host strobe edge. Control-register values, `host_rdata`/`host_rvalid` and the video-RAM request are all due one cycle after the strobe. The read-ahead buffer is refilled two cycles after the request. The bench drives each access for a single cycle and samples every immediate result at the falling edge that follows the capturing edge. It then leaves three idle cycles so that each refill finishes before the next access.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;

    localparam int DW       = 8;
    localparam int HOST_AW  = 16;
    localparam int VRAM_AW  = 14;
    localparam int NUM_CREG = 8;
    localparam int CREG_IW  = $clog2(NUM_CREG);
    localparam logic [HOST_AW-1:0] STAT_OFS = 16'd2;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_REG   = 2'd1,
        CMD_WADDR = 2'd2,
        CMD_RADDR = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_WRITE = 2'd2
    } mem_op_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [VRAM_AW-1:0]   addr;
        logic [CREG_IW-1:0]   idx;
        logic [DW-1:0]        data;
    } cmd_t;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic stat_rd;
        logic ctrl_wr;
    } port_hit_t;

    // Decode a completed byte pair: lo arrived first, hi second.
    function automatic cmd_t build_cmd(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
        cmd_t c;
        c.data = lo;
        c.idx  = hi[CREG_IW-1:0];
        c.addr = {hi[5:0], lo};
        if (hi[7])
            c.kind = CMD_REG;
        else if (hi[6])
            c.kind = CMD_WADDR;
        else
            c.kind = CMD_RADDR;
        return c;
    endfunction

    function automatic port_hit_t decode_port(
        input logic               en,
        input logic               wr,
        input logic [HOST_AW-1:0] addr,
        input logic [HOST_AW-1:0] rd_base,
        input logic [HOST_AW-1:0] gap
    );
        port_hit_t            h;
        logic [HOST_AW-1:0]   wr_base;
        wr_base   = rd_base + gap;
        h.data_rd = en && !wr && (addr == rd_base);
        h.stat_rd = en && !wr && (addr == rd_base + STAT_OFS);
        h.data_wr = en &&  wr && (addr == wr_base);
        h.ctrl_wr = en &&  wr && (addr == wr_base + STAT_OFS);
        return h;
    endfunction

    function automatic logic [DW-1:0] status_byte(input logic frame_flag);
        return {frame_flag, {(DW-1){1'b0}}};
    endfunction

endpackage

// File: rtl/vdp_cmd_asm.sv
module vdp_cmd_asm
    import vdp_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic          abort,
    input  logic [DW-1:0] wdata,
    output cmd_t          cmd
);

    logic          pend_q;
    logic [DW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            lo_q   <= '0;
        end else if (abort) begin
            pend_q <= 1'b0;
        end else if (ctrl_wr) begin
            if (!pend_q) begin
                lo_q   <= wdata;
                pend_q <= 1'b1;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cmd = build_cmd(lo_q, wdata);
        if (!(ctrl_wr && pend_q))
            cmd.kind = CMD_NONE;
    end

    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (cmd.kind == CMD_NONE)); // R4

    AST_FIRST_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != CMD_NONE) |=> (cmd.kind == CMD_NONE)); // R2

endmodule

// File: rtl/vdp_creg_bank.sv
module vdp_creg_bank
    import vdp_host_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CREG_IW-1:0]       idx,
    input  logic [DW-1:0]            data,
    output logic [NUM_CREG*DW-1:0]   regs_flat
);

    for (genvar g = 0; g < NUM_CREG; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (wr_en && (idx == CREG_IW'(g)))
                r_q <= data;
        end
        assign regs_flat[g*DW +: DW] = r_q;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat)); // R2

endmodule

// File: rtl/vdp_vram_seq.sv
module vdp_vram_seq
    import vdp_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_w,
    input  logic               load_r,
    input  logic [VRAM_AW-1:0] new_addr,
    input  logic               data_rd,
    input  logic               data_wr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rbuf,
    output logic               vram_en,
    output logic               vram_we,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [DW-1:0]      vram_wdata,
    input  logic [DW-1:0]      vram_rdata
);

    mem_op_e            op_q;
    logic [VRAM_AW-1:0] addr_q;
    logic [DW-1:0]      wd_q;
    logic [DW-1:0]      rbuf_q;
    logic               cap_q;
    logic               load;

    assign load = load_w || load_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            wd_q   <= '0;
            rbuf_q <= '0;
            cap_q  <= 1'b0;
        end else begin
            cap_q <= (op_q == OP_FETCH);
            if (cap_q)
                rbuf_q <= vram_rdata;
            if (op_q != OP_IDLE) begin
                addr_q <= addr_q + 1'b1;
                op_q   <= OP_IDLE;
            end
            if (data_wr) begin
                op_q   <= OP_WRITE;
                wd_q   <= wdata;
                rbuf_q <= wdata;
            end else if (data_rd) begin
                op_q <= OP_FETCH;
            end
            if (load) begin
                addr_q <= new_addr;
                op_q   <= load_r ? OP_FETCH : OP_IDLE;
            end
        end
    end

    assign vram_en    = (op_q != OP_IDLE);
    assign vram_we    = (op_q == OP_WRITE);
    assign vram_addr  = addr_q;
    assign vram_wdata = wd_q;
    assign rbuf       = rbuf_q;

    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> vram_en); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (vram_en && !load) |=> (vram_addr == $past(vram_addr) + 1'b1)); // R8

    AST_RSETUP_FETCH: assert property (@(posedge clk) disable iff (rst)
        load_r |=> (vram_en && !vram_we && vram_addr == $past(new_addr))); // R6

    AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (rbuf == $past(wdata))); // R7

endmodule

// File: rtl/vdp_status_unit.sv
module vdp_status_unit (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic stat_rd,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (frame_tick)
            flag_q <= 1'b1;
        else if (stat_rd)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> flag); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !frame_tick) |=> !flag); // R9

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_host_pkg::*;
#(
    parameter logic [HOST_AW-1:0] RD_BASE  = 16'h8800,
    parameter logic [HOST_AW-1:0] PORT_GAP = 16'h1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_en,
    input  logic                   host_wr,
    input  logic [HOST_AW-1:0]     host_addr,
    input  logic [DW-1:0]          host_wdata,
    output logic [DW-1:0]          host_rdata,
    output logic                   host_rvalid,
    input  logic                   frame_tick,
    output logic                   irq,
    output logic                   vram_en,
    output logic                   vram_we,
    output logic [VRAM_AW-1:0]     vram_addr,
    output logic [DW-1:0]          vram_wdata,
    input  logic [DW-1:0]          vram_rdata,
    output logic [NUM_CREG*DW-1:0] creg_flat
);

    port_hit_t     hit;
    cmd_t          cmd;
    logic          abort;
    logic          flag;
    logic [DW-1:0] rbuf;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    assign hit   = decode_port(host_en, host_wr, host_addr, RD_BASE, PORT_GAP);
    assign abort = hit.data_rd || hit.data_wr || hit.stat_rd;

    vdp_cmd_asm u_cmd (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (hit.ctrl_wr),
        .abort   (abort),
        .wdata   (host_wdata),
        .cmd     (cmd)
    );

    vdp_creg_bank u_creg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cmd.kind == CMD_REG),
        .idx       (cmd.idx),
        .data      (cmd.data),
        .regs_flat (creg_flat)
    );

    vdp_vram_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .load_w     (cmd.kind == CMD_WADDR),
        .load_r     (cmd.kind == CMD_RADDR),
        .new_addr   (cmd.addr),
        .data_rd    (hit.data_rd),
        .data_wr    (hit.data_wr),
        .wdata      (host_wdata),
        .rbuf       (rbuf),
        .vram_en    (vram_en),
        .vram_we    (vram_we),
        .vram_addr  (vram_addr),
        .vram_wdata (vram_wdata),
        .vram_rdata (vram_rdata)
    );

    vdp_status_unit u_stat (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .stat_rd    (hit.stat_rd),
        .flag       (flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= hit.data_rd || hit.stat_rd;
            if (hit.data_rd)
                rdata_q <= rbuf;
            else if (hit.stat_rd)
                rdata_q <= status_byte(flag);
        end
    end

    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;
    assign irq         = flag;

    AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_en && !host_wr &&
            (host_addr == RD_BASE || host_addr == RD_BASE + STAT_OFS))); // R10

    AST_NO_STRAY_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (host_en && host_addr != RD_BASE + PORT_GAP) |=> !vram_we); // R10

endmodule

// File: tb/vdp_host_port_tb_top.sv
module vdp_host_port_tb_top;

    localparam logic [15:0] DRD  = 16'h8800;
    localparam logic [15:0] STAT = 16'h8802;
    localparam logic [15:0] DWR  = 16'h9800;
    localparam logic [15:0] CTRL = 16'h9802;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_en, host_wr, frame_tick;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_rvalid, irq;
    logic        vram_en, vram_we;
    logic [13:0] vram_addr;
    logic [7:0]  vram_wdata, vram_rdata;
    logic [63:0] creg_flat;

    always #4 clk = ~clk;

    vdp_host_port dut_i (
        .clk(clk), .rst(rst), .host_en(host_en), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .frame_tick(frame_tick), .irq(irq),
        .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata), .creg_flat(creg_flat)
    );

    // Video RAM model aliased on the low address byte; tests read back before reuse.
    logic [7:0] mem [256];
    int         vram_ops = 0;
    always @(posedge clk) begin
        if (vram_en) begin
            vram_ops <= vram_ops + 1;
            if (vram_we) mem[vram_addr[7:0]] <= vram_wdata;
            vram_rdata <= mem[vram_addr[7:0]];
        end
    end

    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic        obs_rv, obs_ven, obs_vwe;
    logic [7:0]  obs_rd, obs_wd;
    logic [13:0] obs_va;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host(input logic wr, input logic [15:0] a, input logic [7:0] d, input logic tick = 1'b0);
        host_en = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; frame_tick = tick;
        @(negedge clk);
        host_en = 1'b0; frame_tick = 1'b0;
        obs_rv = host_rvalid; obs_rd = host_rdata;
        obs_ven = vram_en; obs_vwe = vram_we; obs_va = vram_addr; obs_wd = vram_wdata;
        repeat (3) @(negedge clk);
    endtask

    task automatic ctrl2(input logic [7:0] lo, input logic [7:0] hi);
        host(1'b1, CTRL, lo);
        host(1'b1, CTRL, hi);
    endtask

    function automatic logic [7:0] creg(input int i);
        return creg_flat[i*8 +: 8];
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ops0;
        logic [63:0] snap;
        rst = 1'b1; host_en = 1'b0; host_wr = 1'b0; host_addr = '0;
        host_wdata = '0; frame_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rvalid", host_rvalid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 vram_en", vram_en, 0);
        chk("R1 creg", creg_flat, 0);

        // R9 status after reset
        host(1'b0, STAT, 8'h00);
        chk("R9 status rvalid", obs_rv, 1);
        chk("R9 status idle", obs_rd, 8'h00);

        // R2 first byte alone does nothing
        host(1'b1, CTRL, 8'h3C);
        chk("R2 one byte", creg(3), 8'h00);
        host(1'b1, CTRL, 8'h83);
        chk("R2 second byte", creg(3), 8'h3C);

        // R3 all eight registers
        for (int i = 0; i < 8; i++) ctrl2(8'((i * 37 + 5) & 8'hFF), 8'(8'h80 | i));
        for (int i = 0; i < 8; i++) chk("R3 reg load", creg(i), 8'((i * 37 + 5) & 8'hFF));
        ctrl2(8'hE7, 8'hC2);
        chk("R3 bits 11 is register load", creg(2), 8'hE7);

        // R5 block write at 0x0040
        ctrl2(8'h40, 8'h40);
        for (int i = 0; i < 16; i++) begin
            host(1'b1, DWR, pat(i));
            chk("R5 write strobe", {obs_ven, obs_vwe}, 2'b11);
            chk("R5 write addr", obs_va, 14'h0040 + 14'(i));
            chk("R5 write data", obs_wd, pat(i));
        end
        // R6 read-back
        ctrl2(8'h40, 8'h00);
        chk("R6 setup fetch", {obs_ven, obs_vwe, 2'b00, obs_va}, {2'b10, 2'b00, 14'h0040});
        for (int i = 0; i < 16; i++) begin
            host(1'b0, DRD, 8'h00);
            chk("R6 rvalid", obs_rv, 1);
            chk("R6 read data", obs_rd, pat(i));
        end

        // R7 write fills read-ahead
        ctrl2(8'h00, 8'h41);
        host(1'b1, DWR, 8'h5A);
        host(1'b0, DRD, 8'h00);
        chk("R7 read after write", obs_rd, 8'h5A);

        // R4 address setup interrupted by status read
        host(1'b1, CTRL, 8'h00);
        host(1'b0, STAT, 8'h00);
        ctrl2(8'h00, 8'h42);
        host(1'b1, DWR, 8'hC3);
        chk("R4 status abort addr", obs_va, 14'h0200);
        ctrl2(8'h00, 8'h02);
        host(1'b0, DRD, 8'h00);
        chk("R4 status abort data", obs_rd, 8'hC3);

        // R4 interrupted by data read
        host(1'b1, CTRL, 8'h77);
        host(1'b0, DRD, 8'h00);
        ctrl2(8'h82, 8'h85);
        chk("R4 data-read abort new", creg(5), 8'h82);
        chk("R4 data-read abort old", creg(2), 8'hE7);

        // R4 interrupted by data write
        host(1'b1, CTRL, 8'h33);
        host(1'b1, DWR, 8'h99);
        ctrl2(8'h86, 8'h87);
        chk("R4 data-write abort", creg(7), 8'h86);

        // R8 wrap at end of space
        ctrl2(8'hFE, 8'h7F);
        host(1'b1, DWR, 8'h11);
        chk("R8 addr 3FFE", obs_va, 14'h3FFE);
        host(1'b1, DWR, 8'h22);
        chk("R8 addr 3FFF", obs_va, 14'h3FFF);
        host(1'b1, DWR, 8'h33);
        chk("R8 addr wraps", obs_va, 14'h0000);
        ctrl2(8'hFF, 8'h3F);
        host(1'b0, DRD, 8'h00);
        chk("R8 read 3FFF", obs_rd, 8'h22);
        host(1'b0, DRD, 8'h00);
        chk("R8 read wrapped", obs_rd, 8'h33);

        // R9 frame flag
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        chk("R9 irq set", irq, 1);
        host(1'b0, STAT, 8'h00);
        chk("R9 status flag", obs_rd, 8'h80);
        chk("R9 irq cleared", irq, 0);
        host(1'b0, STAT, 8'h00, 1'b1);
        chk("R9 same-cycle read old", obs_rd, 8'h00);
        chk("R9 same-cycle set wins", irq, 1);
        host(1'b0, STAT, 8'h00);
        chk("R9 flag after tie", obs_rd, 8'h80);

        // R10 decode: ignored accesses
        ops0 = vram_ops;
        snap = creg_flat;
        host(1'b1, DRD, 8'hAA);
        chk("R10 write to read port", obs_rv, 0);
        host(1'b0, DWR, 8'h00);
        chk("R10 read of write port", obs_rv, 0);
        host(1'b0, 16'h8804, 8'h00);
        chk("R10 read other addr", obs_rv, 0);
        host(1'b1, 16'h1234, 8'h81);
        host(1'b1, 16'h1234, 8'h84);
        host(1'b0, CTRL, 8'h00);
        chk("R10 no vram access", vram_ops, ops0);
        chk("R10 regs unchanged", creg_flat, snap);
        ctrl2(8'h5D, 8'h84);
        chk("R10 no stray latch", creg(4), 8'h5D);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule